// File: doc/BRIEF.md
# Three-Mode Bus Register with Output Enable

This block carries an 18-bit word from an input bus to an output bus through one storage stage. That stage works in one of three ways. The choice is made at run time from a latch-enable input and a bus clock input. With latch enable high, the output follows the input directly and the stage reloads on every system clock. With latch enable low, the stage captures the input on each rising edge of the bus clock. At all other times it keeps what it holds.

An active-low output enable decides whether the output bus is driven. The block is synchronous to a fast system clock. The bus clock and latch enable are asynchronous and pass through two-flop synchronisers. A bus-clock rise is found by comparing consecutive synchronised samples. The floating state is given as an active-high drive enable plus a data vector, and an enclosing wrapper turns these into a true high-impedance pin.

Top module: `bus_mode_reg`

## Requirements
- R1: While oe_ni is 1, y_en_o is 0 and y_o is all zeros, whatever the other inputs are.
- R2: While oe_ni is 0, y_en_o is 1.
- R3: Two system clocks after le_i is raised, y_o equals a_i in the same cycle as any later change of a_i (pass mode).
- R4: With le_i low, a rising edge on bus_clk_i stores a_i. The stored word appears on y_o three system clocks after the edge is applied.
- R5: With le_i low and bus_clk_i steady, the stored word does not change when a_i changes.
- R6: When le_i falls, y_o keeps the last value passed through in pass mode.
- R7: The stored word is not disturbed by oe_ni. A capture made while the output floats shows once oe_ni returns low.
- R8: rst_ni low clears the stored word to zero.
- R9: A falling edge on bus_clk_i does not capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 18 | Input data bus |
| le_i | input | 1 | Latch enable, asynchronous; high selects pass mode |
| bus_clk_i | input | 1 | Bus clock, asynchronous; rising edge captures |
| oe_ni | input | 1 | Output enable, active low |
| y_o | output | 18 | Output data, zero while not driven |
| y_en_o | output | 1 | Drive enable for the output bus, active high |

## Verification
Output gating and a bus-clock capture can happen in the same cycle. To provoke this, the bench raises the bus clock while oe_ni holds the output floating, with a new word on a_i. It first confirms that the output stays undriven and zero. It then lowers oe_ni and expects the captured word rather than the old one. A further change of a_i must then leave the output unchanged, which shows that the capture used the edge alone.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_CAPT = 2'd1,
    MODE_HOLD = 2'd2
  } mode_e;
endpackage

// File: rtl/bmr_sync.sv
module bmr_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int LAST = STAGES - 1;

  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg[s] <= '0;
      else if (s == 0) stg[s] <= d_i;
      else             stg[s] <= stg[(s > 0) ? s - 1 : 0];
    end
  end

  assign q_o = stg[LAST];
endmodule

// File: rtl/bmr_ctrl.sv
module bmr_ctrl
  import bmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  le_i,
  input  logic  bus_clk_i,
  output mode_e mode_o
);
  logic [1:0] raw, syn;
  logic       le_s, bclk_s, bclk_q, rise;

  assign raw = {le_i, bus_clk_i};

  bmr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign le_s   = syn[1];
  assign bclk_s = syn[0];

  // previous bus-clock sample tracks in every mode: no stale edge on mode change
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bclk_q <= 1'b0;
    else         bclk_q <= bclk_s;
  end

  assign rise = bclk_s & ~bclk_q;

  always_comb begin
    if (le_s)      mode_o = MODE_PASS;
    else if (rise) mode_o = MODE_CAPT;
    else           mode_o = MODE_HOLD;
  end

  // R4: an edge is a single-cycle event
  a_r4_rise_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> !rise);

  // R9: no capture unless the bus clock was low the cycle before
  a_r9_no_fall_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_CAPT) |-> (bclk_s && !bclk_q));
endmodule

// File: rtl/bmr_store.sv
module bmr_store
  import bmr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  mode_e        mode_i,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else begin
      unique case (mode_i)
        MODE_PASS, MODE_CAPT: q_o <= a_i;
        default:              q_o <= q_o;
      endcase
    end
  end

  a_r3_pass_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_PASS) |=> (q_o == $past(a_i)));

  a_r4_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_CAPT) |=> (q_o == $past(a_i)));

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_HOLD) |=> $stable(q_o));
endmodule

// File: rtl/bus_mode_reg.sv
module bus_mode_reg
  import bmr_pkg::*;
#(
  parameter int W           = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic         le_i,
  input  logic         bus_clk_i,
  input  logic         oe_ni,
  output logic [W-1:0] y_o,
  output logic         y_en_o
);
  mode_e        mode;
  logic [W-1:0] q, data;

  bmr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .le_i     (le_i),
    .bus_clk_i(bus_clk_i),
    .mode_o   (mode)
  );

  bmr_store #(.W(W)) u_store (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mode_i(mode),
    .a_i   (a_i),
    .q_o   (q)
  );

  // pass mode bypasses the storage stage
  assign data   = (mode == MODE_PASS) ? a_i : q;
  assign y_en_o = ~oe_ni;
  assign y_o    = y_en_o ? data : '0;

  // R1: a floating output carries no data
  a_r1_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !y_en_o |-> (y_o == '0));

  // R7: the output enable never alters the stored word while holding
  a_r7_oe_no_disturb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode == MODE_HOLD) && $changed(oe_ni)) |=> $stable(q));
endmodule

// File: tb/sim_bus_mode_reg.sv
module sim_bus_mode_reg;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a = '0;
  logic         le = 1'b0, bclk = 1'b0, oe_n = 1'b0;
  logic [W-1:0] y;
  logic         y_en;
  int           checks = 0, fails = 0;

  always #5 clk = ~clk;

  bus_mode_reg u0 (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a), .le_i(le),
    .bus_clk_i(bclk), .oe_ni(oe_n), .y_o(y), .y_en_o(y_en)
  );

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
    end
  endtask

  task automatic t_reset;
    rst_ni = 1'b0; cyc(2);
    rst_ni = 1'b1; cyc(4);
    chk("R8 reset word", y, '0);
    chk("R2 driven", W'(y_en), W'(1));
  endtask

  task automatic t_float;
    le = 1'b1; a = 18'h3FFFF; oe_n = 1'b1; cyc(4);
    chk("R1 float data", y, '0);
    chk("R1 float enable", W'(y_en), '0);
    oe_n = 1'b0; cyc(1);
    chk("R2 driven again", W'(y_en), W'(1));
  endtask

  task automatic t_pass;
    le = 1'b1; a = 18'h2AAAA; cyc(4);
    chk("R3 pass pattern", y, 18'h2AAAA);
    a = 18'h00000; cyc(1);
    chk("R3 pass low", y, 18'h00000);
    a = 18'h3FFFF; cyc(1);
    chk("R3 pass high", y, 18'h3FFFF);
  endtask

  task automatic t_le_fall;
    le = 1'b1; bclk = 1'b1; a = 18'h15555; cyc(4);
    le = 1'b0; cyc(4);
    a = 18'h0F0F0; cyc(2);
    chk("R6 keeps last pass value", y, 18'h15555);
  endtask

  task automatic t_capture;
    le = 1'b0; bclk = 1'b0; cyc(4);
    a = 18'h3FFFF; bclk = 1'b1; cyc(3);
    chk("R4 capture high", y, 18'h3FFFF);
    a = 18'h12345; cyc(2);
    chk("R5 hold on data change", y, 18'h3FFFF);
    bclk = 1'b0; cyc(4);
    chk("R9 falling edge ignored", y, 18'h3FFFF);
    a = 18'h00000; bclk = 1'b1; cyc(4);
    chk("R4 capture low", y, 18'h00000);
  endtask

  task automatic t_oe_overlap;
    bclk = 1'b0; a = 18'h2468A; oe_n = 1'b1; cyc(4);
    bclk = 1'b1; cyc(4);
    chk("R1 float during capture", y, '0);
    oe_n = 1'b0; cyc(1);
    chk("R7 capture survives float", y, 18'h2468A);
    a = 18'h00001; cyc(2);
    chk("R7 held after re-enable", y, 18'h2468A);
  endtask

  initial begin
    t_reset();
    t_float();
    t_pass();
    t_le_fall();
    t_capture();
    t_oe_overlap();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog actual=%05h expected=%05h", 18'h1, 18'h0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule